// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block sits on a host I/O bus and gives software the classic two-port route into PCI configuration space. A 32-bit address register names the target bus, device, function and register together with an enable flag in bit 31. A four-port data window then carries the actual configuration transfer. The address register occupies I/O ports 0xCF8 to 0xCFB and the data window occupies 0xCFC to 0xCFF. Every other port address falls outside the block's window.

Host accesses of 8, 16 or 32 bits that reach the data window while the enable flag is set are turned into configuration requests on a simple downstream interface. That interface carries the address, the byte size, lane enables and write data, and the target ends each request with an acknowledge. All other accesses are completed locally, with no downstream traffic. Reads that are completed locally return all ones at the access width.

The host raises `io_req` with stable attributes and holds it until `io_done` pulses for one cycle. It then drops the request. A read result is valid in `io_rdata` while `io_done` is high.

Top module: `cfgp_bridge`

## Requirements
- R1: After synchronous reset, `io_done` and `cfg_req` are low and the address register is zero. A 32-bit read of port 0xCF8 returns 0, and a data-window read is not forwarded.
- R2: A 32-bit write (`io_size` 2, or reserved code 3 which acts as 32-bit) to any port 0xCF8..0xCFB loads the whole address register. A 32-bit read of any of those ports returns its full value.
- R3: An 8-bit (`io_size` 0) or 16-bit (`io_size` 1) read of 0xCF8..0xCFB returns 0xFF or 0xFFFF. A read of any port outside 0xCF8..0xCFF returns all ones at the access width. The matching writes leave the address register unchanged.
- R4: With bit 31 of the address register clear, a data-window access raises no `cfg_req`. Reads return 0xFF, 0xFFFF or 0xFFFFFFFF by width, and writes are dropped.
- R5: With bit 31 set, a data-window access raises `cfg_req`. `cfg_addr` is the address register OR'ed with port bits [1:0], and `cfg_we`, `cfg_size` and `cfg_wdata` (right-justified) copy the host access.
- R6: `cfg_be` is the width pattern shifted left by port bits [1:0] and truncated to 4 bits. The width patterns are 0001 for 8-bit, 0011 for 16-bit and 1111 for 32-bit.
- R7: A forwarded access keeps `cfg_req` high with stable fields until `cfg_ack`, and `io_done` stays low meanwhile. A read then returns `cfg_rdata` masked to the access width.
- R8: `io_done` is a single-cycle pulse. It rises one cycle after a locally completed access is accepted, or one cycle after `cfg_ack`. `io_rdata` is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Host access request, held until io_done |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | Host I/O port address |
| io_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| io_wdata | input | 32 | Right-justified write data |
| io_done | output | 1 | Access complete, one-cycle pulse |
| io_rdata | output | 32 | Read result, valid with io_done |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Downstream write flag |
| cfg_addr | output | 32 | Merged configuration address |
| cfg_be | output | 4 | Byte lane enables |
| cfg_size | output | 2 | Access size code |
| cfg_wdata | output | 32 | Right-justified write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ack |

## Verification
The hardest case to reach is a forwarded access whose acknowledge is delayed. During that wait the request must stay frozen while the host sees no completion, and this must hold at an odd port offset where the lane pattern spills past lane 3. The stimulus reaches it by first loading an enabled address through a 32-bit write at an offset port. Reads and writes at ports 0xCFD to 0xCFF then follow, with the bench holding the acknowledge back for a different number of cycles on each. The enable flag is afterwards cleared the same way, to show that the same ports fall back to all-ones answers.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int CFG_DW = 32;
  localparam int CFG_BW = CFG_DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } io_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } xfer_st_e;

  // all-ones pattern of the access width
  function automatic logic [CFG_DW-1:0] width_ones(input logic [1:0] sz);
    logic [CFG_DW-1:0] m;
    case (io_size_e'(sz))
      SZ_BYTE: m = {{(CFG_DW-8){1'b0}}, 8'hFF};
      SZ_HALF: m = {{(CFG_DW-16){1'b0}}, 16'hFFFF};
      default: m = {CFG_DW{1'b1}};
    endcase
    return m;
  endfunction

  // lane enables: width pattern shifted by low port bits, truncated
  function automatic logic [CFG_BW-1:0] lane_enables(input logic [1:0] sz,
                                                     input logic [1:0] lo);
    logic [CFG_BW-1:0] base;
    case (io_size_e'(sz))
      SZ_BYTE: base = 4'b0001;
      SZ_HALF: base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << lo;
  endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int          IO_AW    = 16,
  parameter logic [15:0] WIN_BASE = 16'h0CF8
) (
  input  logic [IO_AW-1:0] addr,
  output logic             in_window,
  output logic             sel_addr,
  output logic             sel_data,
  output logic [1:0]       lane_lo
);
  localparam int HI = IO_AW - 1;
  localparam logic [IO_AW-1:0] BASE_W = IO_AW'(WIN_BASE);

  // window spans eight ports aligned to eight
  assign in_window = (addr[HI:3] == BASE_W[HI:3]);
  assign sel_addr  = in_window && !addr[2];
  assign sel_data  = in_window &&  addr[2];
  assign lane_lo   = addr[1:0];

endmodule

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg #(
  parameter int W      = 32,
  parameter int EN_BIT = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         enabled
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  assign enabled = q[EN_BIT];

endmodule

// File: rtl/cfgp_xfer.sv
module cfgp_xfer
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              forward,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [CFG_DW-1:0] wdata,
  input  logic [CFG_DW-1:0] fwd_addr,
  input  logic [CFG_BW-1:0] fwd_be,
  input  logic [CFG_DW-1:0] local_rdata,
  output logic              idle,
  output logic              io_done,
  output logic [CFG_DW-1:0] io_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [CFG_DW-1:0] cfg_addr,
  output logic [CFG_BW-1:0] cfg_be,
  output logic [1:0]        cfg_size,
  output logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cfg_ack,
  input  logic [CFG_DW-1:0] cfg_rdata
);
  xfer_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      io_done   <= 1'b0;
      io_rdata  <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_be    <= '0;
      cfg_size  <= 2'd0;
      cfg_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          io_done <= 1'b0;
          if (start) begin
            if (forward) begin
              cfg_req   <= 1'b1;
              cfg_we    <= we;
              cfg_addr  <= fwd_addr;
              cfg_be    <= fwd_be;
              cfg_size  <= size;
              cfg_wdata <= wdata;
              st        <= ST_WAIT;
            end else begin
              io_done  <= 1'b1;
              io_rdata <= local_rdata;
              st       <= ST_RESP;
            end
          end
        end
        ST_WAIT: begin
          if (cfg_ack) begin
            cfg_req  <= 1'b0;
            io_done  <= 1'b1;
            io_rdata <= cfg_we ? '0 : (cfg_rdata & width_ones(cfg_size));
            st       <= ST_RESP;
          end
        end
        default: begin
          io_done <= 1'b0;
          st      <= ST_IDLE;
        end
      endcase
    end
  end

  assign idle = (st == ST_IDLE);

  // R7: request and its fields frozen until acknowledged
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_be)
                                && $stable(cfg_wdata) && $stable(cfg_we)));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    io_done |=> !io_done);

  // R7: no completion while a downstream request is still open
  a_r7_no_early_done: assert property (@(posedge clk) disable iff (rst)
    !(io_done && cfg_req));

endmodule

// File: rtl/cfgp_bridge.sv
module cfgp_bridge
  import cfgp_pkg::*;
#(
  parameter int          IO_AW    = 16,
  parameter logic [15:0] WIN_BASE = 16'h0CF8,
  parameter int          EN_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [1:0]        io_size,
  input  logic [31:0]       io_wdata,
  output logic              io_done,
  output logic [31:0]       io_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [31:0]       cfg_addr,
  output logic [3:0]        cfg_be,
  output logic [1:0]        cfg_size,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_ack,
  input  logic [31:0]       cfg_rdata
);
  logic              in_window, sel_addr, sel_data;
  logic [1:0]        lane_lo;
  logic              idle, accept, is_word, addr_load, cfg_on, forward;
  logic [CFG_DW-1:0] addr_q, local_rdata, merged_addr;
  logic [CFG_BW-1:0] be_calc;

  cfgp_decode #(.IO_AW(IO_AW), .WIN_BASE(WIN_BASE)) dec_i (
    .addr(io_addr), .in_window(in_window), .sel_addr(sel_addr),
    .sel_data(sel_data), .lane_lo(lane_lo)
  );

  assign accept    = io_req && idle;
  assign is_word   = io_size[1];
  assign addr_load = accept && io_we && sel_addr && is_word;

  cfgp_addr_reg #(.W(CFG_DW), .EN_BIT(EN_BIT)) areg_i (
    .clk(clk), .rst(rst), .load(addr_load), .d(io_wdata),
    .q(addr_q), .enabled(cfg_on)
  );

  assign forward     = sel_data && cfg_on;
  assign merged_addr = addr_q | {{(CFG_DW-2){1'b0}}, lane_lo};
  assign be_calc     = lane_enables(io_size, lane_lo);

  always_comb begin
    if (io_we)                    local_rdata = '0;
    else if (sel_addr && is_word) local_rdata = addr_q;
    else                          local_rdata = width_ones(io_size);
  end

  cfgp_xfer xfer_i (
    .clk(clk), .rst(rst), .start(accept), .forward(forward),
    .we(io_we), .size(io_size), .wdata(io_wdata),
    .fwd_addr(merged_addr), .fwd_be(be_calc), .local_rdata(local_rdata),
    .idle(idle), .io_done(io_done), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  // R4: a new downstream request only appears with the enable flag set
  a_r4_fwd_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> cfg_addr[EN_BIT]);

  // R5: upper address bits come straight from the address register
  a_r5_addr_merge: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> (cfg_addr[CFG_DW-1:2] == addr_q[CFG_DW-1:2]));

  // R3: the address register moves only on a 32-bit address-port write
  a_r3_reg_hold: assert property (@(posedge clk) disable iff (rst)
    !addr_load |=> $stable(addr_q));

  // R6: every forwarded request enables at least one lane
  a_r6_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> (cfg_be != '0));

endmodule

// File: tb/cfgp_bridge_tb_top.sv
module cfgp_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_done;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [3:0]  cfg_be;
  logic [1:0]  cfg_size;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfgp_bridge dut_i (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_done(io_done),
    .io_rdata(io_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [15:0] port;
    logic [31:0] wd;
    logic [31:0] ds;     // downstream read data
    logic        fwd;    // expect forwarding
    logic [31:0] xaddr;
    logic [3:0]  xbe;
    logic [31:0] xrd;
    logic [3:0]  dly;    // ack delay
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 16'h0CF8, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h00000000, 4'd0},        // R1 reset value
    '{1'b0, 2'd2, 16'h0CFC, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'hFFFFFFFF, 4'd0},        // R4 word gated
    '{1'b0, 2'd0, 16'h0CFD, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h000000FF, 4'd0},        // R4 byte gated
    '{1'b1, 2'd2, 16'h0CFC, 32'h11, 32'h0, 1'b0, 32'h0, 4'h0, 32'h00000000, 4'd0},       // R4 write dropped
    '{1'b1, 2'd2, 16'h0CFA, 32'h80001234, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 4'd0},        // R2 load at offset
    '{1'b0, 2'd2, 16'h0CF8, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h80001234, 4'd0},        // R2 readback
    '{1'b0, 2'd1, 16'h0CF8, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0000FFFF, 4'd0},        // R3 half read
    '{1'b1, 2'd0, 16'h0CF9, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h00000000, 4'd0},        // R3 byte write ignored
    '{1'b0, 2'd2, 16'h0CFB, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h80001234, 4'd0},        // R3 / R2 unchanged
    '{1'b0, 2'd2, 16'h0CFC, 32'h0, 32'hA5A51234, 1'b1, 32'h80001234, 4'hF, 32'hA5A51234, 4'd0}, // R5 R6 R7
    '{1'b0, 2'd0, 16'h0CFE, 32'h0, 32'hDEADBEEF, 1'b1, 32'h80001236, 4'h4, 32'h000000EF, 4'd3}, // R7 byte mask
    '{1'b0, 2'd1, 16'h0CFF, 32'h0, 32'hCAFEF00D, 1'b1, 32'h80001237, 4'h8, 32'h0000F00D, 4'd1}, // R6 truncation
    '{1'b1, 2'd1, 16'h0CFD, 32'h0000BEEF, 32'h0, 1'b1, 32'h80001235, 4'h6, 32'h0, 4'd6},     // R5 write, R8
    '{1'b1, 2'd3, 16'h0CF8, 32'h00000010, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 4'd0},        // R2 reserved size
    '{1'b0, 2'd1, 16'h0CFE, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0000FFFF, 4'd0},        // R4 half gated
    '{1'b0, 2'd2, 16'h0CF0, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'hFFFFFFFF, 4'd0},        // R3 outside window
    '{1'b1, 2'd2, 16'h0CF4, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 4'd0},               // R3 outside write
    '{1'b0, 2'd0, 16'h1CFC, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h000000FF, 4'd0},        // R3 alias port
    '{1'b0, 2'd2, 16'h0CF8, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h00000010, 4'd0}         // R3 register kept
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input string tag);
    int   waitc = 0;
    logic seen = 1'b0, got = 1'b0;
    @(negedge clk);
    io_req = 1'b1; io_we = v.we; io_size = v.sz;
    io_addr = v.port; io_wdata = v.wd;
    while (!got && waitc < 200) begin
      @(negedge clk);
      waitc++;
      if (cfg_ack) cfg_ack = 1'b0;
      if (io_done) got = 1'b1;
      else if (cfg_req && !seen) begin
        seen = 1'b1;
        chk(cfg_addr == v.xaddr, {tag, " R5 addr"}, cfg_addr, v.xaddr);
        chk(cfg_be == v.xbe, {tag, " R6 be"}, {28'h0, cfg_be}, {28'h0, v.xbe});
        chk(cfg_we == v.we && cfg_size == v.sz, {tag, " R5 we/size"},
            {29'h0, cfg_we, cfg_size}, {29'h0, v.we, v.sz});
        if (v.we) chk(cfg_wdata == v.wd, {tag, " R5 wdata"}, cfg_wdata, v.wd);
        for (int k = 0; k < int'(v.dly); k++) begin
          @(negedge clk);
          waitc++;
          chk(!io_done && cfg_req && cfg_addr == v.xaddr, {tag, " R7 hold"},
              {31'h0, io_done}, 32'h0);
        end
        cfg_ack = 1'b1; cfg_rdata = v.ds;
      end
    end
    chk(got, {tag, " R8 done"}, {31'h0, got}, 32'h1);
    chk(seen == v.fwd, {tag, " R4/R5 forward"}, {31'h0, seen}, {31'h0, v.fwd});
    chk(io_rdata == v.xrd, {tag, " rdata"}, io_rdata, v.xrd);
    io_req = 1'b0;
    @(negedge clk);
    chk(!io_done, {tag, " R8 pulse"}, {31'h0, io_done}, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: idle outputs during and right after reset
    chk(!io_done && !cfg_req, "R1 reset outputs", {30'h0, io_done, cfg_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!io_done && !cfg_req, "R1 post reset", {30'h0, io_done, cfg_req}, 32'h0);

    for (int i = 0; i < NV; i++) run(VECS[i], $sformatf("vec%0d", i));

    // R1: reset clears an enabled address register
    run('{1'b1, 2'd2, 16'h0CF8, 32'h8000ABC0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 4'd0}, "r1_arm");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    run('{1'b0, 2'd2, 16'h0CF8, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 4'd0}, "R1 cleared");
    run('{1'b0, 2'd2, 16'h0CFC, 32'h0, 32'h0, 1'b0, 32'h0, 4'h0, 32'hFFFFFFFF, 4'd0}, "R1 gated");

    // R7 R6: long ack wait with 32-bit access at offset 1 (lanes 1110)
    run('{1'b1, 2'd2, 16'h0CFB, 32'h80FF0100, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 4'd0}, "R2 arm");
    run('{1'b0, 2'd2, 16'h0CFD, 32'h0, 32'h01234567, 1'b1, 32'h80FF0101, 4'hE, 32'h01234567, 4'd9}, "R7 long wait");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule